// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block runs next to a simple instruction fetch unit and repeats a block of code a set number of times without any branch instruction in the body. When the loop instruction executes, the block receives a strobe with a repeat count, the address of the first body word, and the address of the last body word. It then watches each prefetch address. When the prefetch lands on the stored last-word address and passes remain, it tells the fetch unit that the next fetch goes back to the first body word. On the last pass it lets the fetch run on in sequence.

The repeat count is a down-counter. It steps down once for each prefetch of the last word. The loop ends only when a step is requested with the counter already at zero, so a count of N runs the body N+1 times. Two short shapes work with no special logic. In the first, the last word is the first body word itself, so one instruction repeats. In the second, the last word is the loop instruction's own second word, one word before the body. Here the fall-through address after the final pass is the body start again. Instruction words are 2 address units apart by default.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset, `loop_active` is 0 and `redirect` is 0.
- R2: A cycle with `do_start` high loads the count, start address and end address, and `loop_active` is 1 from the next cycle. In that cycle `redirect` stays 0, even if the prefetch matches an old end address.
- R3: While `loop_active` is 1, a valid prefetch whose address equals the stored end address, with the counter non-zero, raises `redirect` for that cycle only. In that cycle `next_pc` equals the stored start address.
- R4: Each prefetch that matches the end address lowers the counter by one. A loaded count of N yields exactly N redirects. The (N+1)th match raises no redirect, gives `next_pc` = end address + STEP, and `loop_active` reads 0 from the next cycle.
- R5: With `loop_active` at 0, with `pf_valid` at 0, or with an address that does not match, `redirect` is 0 and `next_pc` is `pf_addr` + STEP. A prefetch with `pf_valid` low does not use up a pass.
- R6: When the end address equals the start address (one-instruction body), each valid prefetch of that address redirects back to itself until the count is used up. That address is fetched count+1 times, and the run then falls through to the next word.
- R7: When the end address is one word below the start address (the loop instruction's second word), each match redirects to the start. After the last pass the fall-through `next_pc` equals the start address.
- R8: A `do_start` while a loop is active discards the old loop. The new count and addresses apply from the next cycle.
- R9: A loaded count of 0 ends the loop on the first match, with no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| do_start | input | 1 | Loop instruction strobe: load a new loop |
| do_count | input | CW | Repeat count (body runs count+1 times) |
| do_start_addr | input | AW | Address of the first body word |
| do_end_addr | input | AW | Address of the last body word |
| pf_valid | input | 1 | Prefetch address is valid this cycle |
| pf_addr | input | AW | Current prefetch address |
| redirect | output | 1 | Next fetch is forced to the loop start |
| next_pc | output | AW | Address the fetch unit uses next |
| loop_active | output | 1 | A loop is in progress |

## Verification
The hardest case to reach from the ports is the edge of the count. The counter must reach zero and then get one more match, and that last match must fall through to the right address for each loop shape. The one-word-below-start shape is the hardest, because its fall-through address is the loop start itself. The bench drives prefetch streams that revisit the end address exactly count+1 times. It covers the normal body, the one-instruction body, the backward-by-one-word end, a zero count, and the largest count. A reference model in the scoreboard predicts `redirect`, `next_pc` and `loop_active` in every cycle. Invalid prefetches at the end address, and a reload that coincides with an end match, are mixed in so that a pass taken on the wrong event shows up.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

   // Event taken by the controller in a cycle.
   typedef enum logic [1:0] {
      EV_IDLE   = 2'd0,
      EV_REPEAT = 2'd1,
      EV_EXIT   = 2'd2,
      EV_LOAD   = 2'd3
   } loop_ev_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/hwloop_counter.sv
module hwloop_counter #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          dec,
   output logic [CW-1:0] cnt,
   output logic          borrow
);

   initial begin
      if (CW < 1) $error("hwloop_counter: CW must be at least 1");
   end

   logic at_zero;
   assign at_zero = (cnt == '0);
   assign borrow  = dec && at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (load)          cnt <= load_val;
      else if (dec && !at_zero) cnt <= cnt - 1'b1;
   end

endmodule

// File: rtl/hwloop_match.sv
module hwloop_match #(
   parameter int unsigned AW    = 16,
   parameter int unsigned LSB_W = 1
) (
   input  logic          en,
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] target,
   output logic          hit
);

   initial begin
      if (LSB_W >= AW) $error("hwloop_match: LSB_W must be below AW");
   end

   generate
      if (LSB_W > 0) begin : g_word
         // Word-aligned fetch: byte offset bits never differ, skip them.
         assign hit = en && (addr[AW-1:LSB_W] == target[AW-1:LSB_W]);
      end else begin : g_full
         assign hit = en && (addr == target);
      end
   endgenerate

endmodule

// File: rtl/hwloop_ctx.sv
module hwloop_ctx #(
   parameter int unsigned AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          clear,
   input  logic [AW-1:0] start_in,
   input  logic [AW-1:0] end_in,
   output logic [AW-1:0] start_q,
   output logic [AW-1:0] end_q,
   output logic          active_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q  <= '0;
         end_q    <= '0;
         active_q <= 1'b0;
      end else if (load) begin
         start_q  <= start_in;
         end_q    <= end_in;
         active_q <= 1'b1;
      end else if (clear) begin
         active_q <= 1'b0;
      end
   end

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
   import hwloop_pkg::*;
#(
   parameter int unsigned AW   = 16,
   parameter int unsigned CW   = 8,
   parameter int unsigned STEP = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          do_start,
   input  logic [CW-1:0] do_count,
   input  logic [AW-1:0] do_start_addr,
   input  logic [AW-1:0] do_end_addr,
   input  logic          pf_valid,
   input  logic [AW-1:0] pf_addr,
   output logic          redirect,
   output logic [AW-1:0] next_pc,
   output logic          loop_active
);

   localparam int unsigned LSB_W = (STEP > 1) ? $clog2(STEP) : 0;
   localparam logic [AW-1:0] STEP_V = AW'(STEP);

   initial begin
      if (!is_pow2(STEP)) $error("hwloop_ctrl: STEP must be a power of two");
      if (AW <= LSB_W)    $error("hwloop_ctrl: AW too small for STEP");
      if (CW < 1)         $error("hwloop_ctrl: CW must be at least 1");
   end

   logic [AW-1:0] loop_start;
   logic [AW-1:0] loop_end;
   logic [CW-1:0] iter_cnt;
   logic          end_hit;
   logic          cnt_borrow;
   logic          take_pass;
   loop_ev_e      ev;

   hwloop_ctx #(.AW(AW)) u_ctx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (do_start),
      .clear    (ev == EV_EXIT),
      .start_in (do_start_addr),
      .end_in   (do_end_addr),
      .start_q  (loop_start),
      .end_q    (loop_end),
      .active_q (loop_active)
   );

   hwloop_match #(.AW(AW), .LSB_W(LSB_W)) u_match (
      .en     (loop_active && pf_valid),
      .addr   (pf_addr),
      .target (loop_end),
      .hit    (end_hit)
   );

   // A reload takes priority over any match against the old loop.
   assign take_pass = end_hit && !do_start;

   hwloop_counter #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (do_start),
      .load_val (do_count),
      .dec      (take_pass),
      .cnt      (iter_cnt),
      .borrow   (cnt_borrow)
   );

   always_comb begin
      if (do_start)                     ev = EV_LOAD;
      else if (take_pass && cnt_borrow) ev = EV_EXIT;
      else if (take_pass)               ev = EV_REPEAT;
      else                              ev = EV_IDLE;
   end

   assign redirect = (ev == EV_REPEAT);
   assign next_pc  = redirect ? loop_start : (pf_addr + STEP_V);

endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk #(
   parameter int unsigned AW   = 16,
   parameter int unsigned CW   = 8,
   parameter int unsigned STEP = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          do_start,
   input logic          pf_valid,
   input logic [AW-1:0] pf_addr,
   input logic          redirect,
   input logic [AW-1:0] next_pc,
   input logic          loop_active,
   input logic [AW-1:0] loop_start,
   input logic [AW-1:0] loop_end,
   input logic [CW-1:0] iter_cnt
);

   a_r5_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!loop_active || !pf_valid) |-> !redirect);

   a_r2_load_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
      do_start |=> loop_active);

   a_r2_load_blocks_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      do_start |-> !redirect);

   a_r3_target_is_start: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> (next_pc == loop_start) && (pf_addr == loop_end));

   a_r4_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect && !do_start) |=> (iter_cnt == $past(iter_cnt) - 1'b1));

   a_r4_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_active && pf_valid && pf_addr == loop_end && iter_cnt == '0 && !do_start)
         |=> !loop_active);

endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.AW(AW), .CW(CW), .STEP(STEP)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .do_start    (do_start),
   .pf_valid    (pf_valid),
   .pf_addr     (pf_addr),
   .redirect    (redirect),
   .next_pc     (next_pc),
   .loop_active (loop_active),
   .loop_start  (loop_start),
   .loop_end    (loop_end),
   .iter_cnt    (iter_cnt)
);

// File: tb/hwloop_ctrl_bench.sv
`timescale 1ns/1ps
module hwloop_ctrl_bench;

   localparam int AW = 16;
   localparam int CW = 8;
   localparam int STEP = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          do_start = 1'b0;
   logic [CW-1:0] do_count = '0;
   logic [AW-1:0] do_start_addr = '0;
   logic [AW-1:0] do_end_addr = '0;
   logic          pf_valid = 1'b0;
   logic [AW-1:0] pf_addr = '0;
   logic          redirect;
   logic [AW-1:0] next_pc;
   logic          loop_active;

   always #2.5 clk = ~clk;

   hwloop_ctrl #(.AW(AW), .CW(CW), .STEP(STEP)) u_hwloop_ctrl (
      .clk(clk), .rst_n(rst_n), .do_start(do_start), .do_count(do_count),
      .do_start_addr(do_start_addr), .do_end_addr(do_end_addr),
      .pf_valid(pf_valid), .pf_addr(pf_addr), .redirect(redirect),
      .next_pc(next_pc), .loop_active(loop_active)
   );

   int checks = 0;
   int failures = 0;
   int obs_redirects = 0;

   // Scoreboard queues
   logic          q_red [$];
   logic [AW-1:0] q_pc  [$];
   logic          q_act [$];
   string         q_tag [$];

   // Reference model state
   logic          m_act = 1'b0;
   logic [CW-1:0] m_cnt = '0;
   logic [AW-1:0] m_start = '0;
   logic [AW-1:0] m_end = '0;

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Driver: apply one cycle of stimulus and push the predicted outputs.
   task automatic drive(input logic ds, input logic [CW-1:0] cnt,
                        input logic [AW-1:0] s, input logic [AW-1:0] e,
                        input logic v, input logic [AW-1:0] a, input string tag);
      logic hit, red;
      @(posedge clk);
      #1;
      do_start = ds; do_count = cnt; do_start_addr = s; do_end_addr = e;
      pf_valid = v;  pf_addr = a;
      hit = m_act && v && (a == m_end) && !ds;
      red = hit && (m_cnt != '0);
      q_red.push_back(red);
      q_pc.push_back(red ? m_start : AW'(a + STEP));
      q_act.push_back(m_act);
      q_tag.push_back(tag);
      if (ds) begin
         m_act = 1'b1; m_cnt = cnt; m_start = s; m_end = e;
      end else if (hit) begin
         if (m_cnt == '0) m_act = 1'b0;
         else             m_cnt = m_cnt - 1'b1;
      end
   endtask

   task automatic fetch(input logic v, input logic [AW-1:0] a, input string tag);
      drive(1'b0, '0, '0, '0, v, a, tag);
   endtask

   task automatic start_loop(input logic [CW-1:0] cnt, input logic [AW-1:0] s,
                             input logic [AW-1:0] e, input logic [AW-1:0] a,
                             input string tag);
      drive(1'b1, cnt, s, e, 1'b1, a, tag);
   endtask

   // Monitor: compare at the falling edge, away from the active edge.
   always @(negedge clk) begin
      if (q_red.size() > 0) begin
         string t;
         t = q_tag.pop_front();
         if (redirect === 1'b1) obs_redirects++;
         check(t, "redirect",    32'(redirect),    32'(q_red.pop_front()));
         check(t, "next_pc",     32'(next_pc),     32'(q_pc.pop_front()));
         check(t, "loop_active", 32'(loop_active), 32'(q_act.pop_front()));
      end
   end

   task automatic drain();
      @(posedge clk); #1;
      pf_valid = 1'b0; do_start = 1'b0;
      @(negedge clk); @(negedge clk);
   endtask

   bit done = 1'b0;

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog all-requirements actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: idle outputs held in reset
      check("R1", "loop_active in reset", 32'(loop_active), 32'd0);
      check("R1", "redirect in reset",    32'(redirect),    32'd0);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1", "loop_active after reset", 32'(loop_active), 32'd0);

      // R5: inactive controller passes sequential addresses through
      fetch(1'b1, 16'h0040, "R5");
      fetch(1'b1, 16'h0042, "R5");
      fetch(1'b1, 16'h0000, "R5");

      // R3 R4: four-word body, count 2 -> three passes
      start_loop(8'd2, 16'h0104, 16'h010A, 16'h0100, "R2");
      for (int p = 0; p < 3; p++) begin
         fetch(1'b1, 16'h0104, "R3");
         fetch(1'b1, 16'h0106, "R3");
         // R5: invalid prefetch on the end address consumes nothing
         fetch(1'b0, 16'h010A, "R5");
         fetch(1'b1, 16'h0108, "R3");
         fetch(1'b1, 16'h010A, "R4");
      end
      fetch(1'b1, 16'h010C, "R4");

      // R6: one-instruction body, count 3 -> fetched four times
      start_loop(8'd3, 16'h0204, 16'h0204, 16'h0202, "R6");
      for (int p = 0; p < 4; p++) fetch(1'b1, 16'h0204, "R6");
      fetch(1'b1, 16'h0206, "R6");

      // R7: end one word before the start, count 1
      start_loop(8'd1, 16'h0304, 16'h0302, 16'h0300, "R7");
      fetch(1'b1, 16'h0302, "R7");
      fetch(1'b1, 16'h0304, "R7");
      fetch(1'b1, 16'h0302, "R7");
      fetch(1'b1, 16'h0304, "R7");

      // R9: zero count ends on the first match
      start_loop(8'd0, 16'h0404, 16'h0406, 16'h0400, "R9");
      fetch(1'b1, 16'h0404, "R9");
      fetch(1'b1, 16'h0406, "R9");
      fetch(1'b1, 16'h0408, "R9");

      // R8 R2: reload mid-loop, reload coinciding with an old end match
      start_loop(8'd5, 16'h0504, 16'h0508, 16'h0500, "R8");
      fetch(1'b1, 16'h0504, "R8");
      fetch(1'b1, 16'h0508, "R8");
      start_loop(8'd1, 16'h0604, 16'h0606, 16'h0508, "R2");
      fetch(1'b1, 16'h0508, "R8");
      fetch(1'b1, 16'h0606, "R8");
      fetch(1'b1, 16'h0606, "R8");
      fetch(1'b1, 16'h0608, "R8");

      // R4: largest count gives exactly that many redirects
      drain();
      obs_redirects = 0;
      start_loop(8'd255, 16'h0704, 16'h0706, 16'h0700, "R4");
      for (int p = 0; p < 256; p++) begin
         fetch(1'b1, 16'h0704, "R4");
         fetch(1'b1, 16'h0706, "R4");
      end
      fetch(1'b1, 16'h0708, "R4");
      drain();
      check("R4", "redirect total for count 255", 32'(obs_redirects), 32'd255);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule